// File: doc/BRIEF.md
# Block-Lock Write Guard

This unit owns the protection state of a small byte-addressed nonvolatile store and decides whether each write may go ahead. It holds a write-enable latch, a software flag, a two-bit zone code that locks the upper quarter, the upper half or the whole array, and a lock-enable bit. The lock-enable bit works with an active-low lock pin: when both are engaged, the status register is frozen until the pin goes back high. It also models the self-timed write cycle. While that cycle runs, a busy bit is set and new requests are held off.

Write requests reach the unit on a valid/ready channel. Each request is either an array write (address) or a status write (data byte). `req_ready` is high whenever no write cycle is running. A request is taken on any clock edge where `req_valid` and `req_ready` are both high. A taken request that is allowed starts a write cycle. A taken request that is refused is dropped and changes no state. Because of this, a sender never waits longer than one write cycle. Single-cycle command strobes set or clear the enable latch and the flag. Two outputs are combinational: `arr_wr_ok` says whether an array write to the address now on `req_addr` would be allowed, and `sr_wr_ok` says whether a status write would be allowed. The status byte is always visible.

Nonvolatile bits are plain registers loaded from parameters at reset.

Top module: `blk_lock_guard`

## Requirements
- R1: `status_byte` is {lock-enable, flag, 0, 0, zone[1], zone[0], enable latch, busy}, bit 7 first; after reset the volatile bits are 0 and the lock-enable and zone bits take their parameter values, which default to 0.
- R2: `arr_wr_ok` is 1 only when the enable latch is 1 and `req_addr` lies outside the locked zone. With DEPTH = 2^ADDR_W, zone code 00 locks nothing, 01 locks addresses from 3*DEPTH/4 up, 10 locks addresses from DEPTH/2 up, and 11 locks every address.
- R3: `sr_wr_ok` is 1 only when the enable latch is 1 and lock-enable is not combined with `hw_lock_n` low. A status request refused for this reason changes no state.
- R4: `cmd_wel_set` sets the enable latch and `cmd_wel_clr` clears it. When both are high together, clear wins. While busy, both strobes are ignored.
- R5: `cmd_flag_set` sets the flag and `cmd_flag_clr` clears it. When both are high together, clear wins. While busy, both strobes are ignored. The flag is 0 after reset.
- R6: `req_ready` equals NOT busy. A taken request that is allowed sets busy from the next cycle for exactly WR_CYCLES cycles. A refused request leaves busy at 0.
- R7: A status request with data bits 1 or 0 set is refused.
- R8: When a write cycle ends, the enable latch is cleared. A status write then loads lock-enable from data bit 7 and the zone from data bits 3:2. The flag, the enable latch and the busy bit are never loaded from data.
- R9: Driving `hw_lock_n` low during a status write cycle that is already running does not cancel it. Later status writes are refused while the pin stays low.
- R10: An array write changes no status bit other than the enable latch and busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hw_lock_n | input | 1 | Lock pin, active low |
| cmd_wel_set | input | 1 | Set enable latch strobe |
| cmd_wel_clr | input | 1 | Clear enable latch strobe |
| cmd_flag_set | input | 1 | Set flag strobe |
| cmd_flag_clr | input | 1 | Clear flag strobe |
| req_valid | input | 1 | Write request valid |
| req_ready | output | 1 | Request can be taken (not busy) |
| req_kind | input | 1 | 0 array write, 1 status write |
| req_addr | input | ADDR_W | Array write start address |
| req_data | input | 8 | Status write data |
| arr_wr_ok | output | 1 | Array write to req_addr allowed |
| sr_wr_ok | output | 1 | Status write allowed |
| status_byte | output | 8 | Assembled status |

## Verification
Address probes sit on both sides of every zone boundary for each zone code, so that an off-by-one or a swapped zone code shows up as a wrong `arr_wr_ok`. Status writes are tried with the pin high, with the pin low while lock-enable is set, with the pin dropped in the middle of a cycle, and with illegal low data bits. These cases separate pin-gating from data checking and from the "already started" rule. Strobes arrive alone, in conflicting pairs and during busy, which exposes wrong priority and missing busy gating. A behavioural model is compared with every output on every clock.

// File: rtl/blg_pkg.sv
package blg_pkg;
  localparam int unsigned SR_W = 8;

  typedef enum logic {
    REQ_ARRAY  = 1'b0,
    REQ_STATUS = 1'b1
  } req_kind_e;

  typedef struct packed {
    logic       lock_en;
    logic       flag;
    logic [1:0] zone;
    logic       wel;
    logic       wip;
  } sr_fields_t;

  function automatic logic [SR_W-1:0] pack_status(input sr_fields_t f);
    return {f.lock_en, f.flag, 2'b00, f.zone, f.wel, f.wip};
  endfunction
endpackage

// File: rtl/blg_zone_decode.sv
module blg_zone_decode #(
  parameter int unsigned ADDR_W = 11
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        zone,
  output logic              hit
);
  // Top quarter: two MSBs both set. Top half: MSB set.
  logic top_quarter;
  logic top_half;

  assign top_quarter = &addr[ADDR_W-1 -: 2];
  assign top_half    = addr[ADDR_W-1];

  always_comb begin
    unique case (zone)
      2'b00:   hit = 1'b0;
      2'b01:   hit = top_quarter;
      2'b10:   hit = top_half;
      default: hit = 1'b1;
    endcase
  end
endmodule

// File: rtl/blg_cycle_timer.sv
module blg_cycle_timer #(
  parameter int unsigned CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int unsigned CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;
  localparam logic [CW-1:0] LOAD = CW'(CYCLES - 1);

  logic [CW-1:0] cnt;

  assign done = busy && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start && !busy) begin
      busy <= 1'b1;
      cnt  <= LOAD;
    end else if (done) begin
      busy <= 1'b0;
    end else if (busy) begin
      cnt <= cnt - 1'b1;
    end
  end

  AST_TIMER_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy) else $error("timer dropped early"); // R6
endmodule

// File: rtl/blg_status_core.sv
module blg_status_core #(
  parameter logic       INIT_LOCK_EN = 1'b0,
  parameter logic [1:0] INIT_ZONE    = 2'b00
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       busy,
  input  logic       done,
  input  logic       cmd_wel_set,
  input  logic       cmd_wel_clr,
  input  logic       cmd_flag_set,
  input  logic       cmd_flag_clr,
  input  logic       start_status,
  input  logic       pend_lock_in,
  input  logic [1:0] pend_zone_in,
  output logic       wel,
  output logic       flag,
  output logic       lock_en,
  output logic [1:0] zone
);
  logic       pend_is_status;
  logic       pend_lock;
  logic [1:0] pend_zone;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel            <= 1'b0;
      flag           <= 1'b0;
      lock_en        <= INIT_LOCK_EN;
      zone           <= INIT_ZONE;
      pend_is_status <= 1'b0;
      pend_lock      <= 1'b0;
      pend_zone      <= 2'b00;
    end else if (done) begin
      wel <= 1'b0;
      if (pend_is_status) begin
        lock_en <= pend_lock;
        zone    <= pend_zone;
      end
    end else if (!busy) begin
      if (cmd_wel_clr)       wel <= 1'b0;
      else if (cmd_wel_set)  wel <= 1'b1;
      if (cmd_flag_clr)      flag <= 1'b0;
      else if (cmd_flag_set) flag <= 1'b1;
      pend_is_status <= start_status;
      if (start_status) begin
        pend_lock <= pend_lock_in;
        pend_zone <= pend_zone_in;
      end
    end
  end

  AST_FLAG_FROZEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $past(busy) |-> $stable(flag)) else $error("flag moved while busy"); // R5
  AST_WEL_CLEARED_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !wel) else $error("latch kept after cycle"); // R8
endmodule

// File: rtl/blk_lock_guard.sv
module blk_lock_guard
  import blg_pkg::*;
#(
  parameter int unsigned ADDR_W       = 11,
  parameter int unsigned WR_CYCLES    = 8,
  parameter logic        INIT_LOCK_EN = 1'b0,
  parameter logic [1:0]  INIT_ZONE    = 2'b00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hw_lock_n,
  input  logic              cmd_wel_set,
  input  logic              cmd_wel_clr,
  input  logic              cmd_flag_set,
  input  logic              cmd_flag_clr,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_kind,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [7:0]        req_data,
  output logic              arr_wr_ok,
  output logic              sr_wr_ok,
  output logic [7:0]        status_byte
);
  logic       busy, done;
  logic       wel, flag, lock_en;
  logic [1:0] zone;
  logic       zone_hit;
  logic       take, is_status, data_legal, allowed, start;
  logic       data_unused;
  sr_fields_t fields;

  blg_zone_decode #(.ADDR_W(ADDR_W)) u_zone (
    .addr (req_addr),
    .zone (zone),
    .hit  (zone_hit)
  );

  blg_cycle_timer #(.CYCLES(WR_CYCLES)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .busy  (busy),
    .done  (done)
  );

  assign is_status   = (req_kind == REQ_STATUS);
  assign data_legal  = (req_data[1:0] == 2'b00);
  assign data_unused = ^req_data[6:4];
  assign arr_wr_ok   = wel && !zone_hit;
  assign sr_wr_ok    = wel && !(lock_en && !hw_lock_n);
  assign req_ready   = !busy;
  assign take        = req_valid && req_ready;
  assign allowed     = is_status ? (sr_wr_ok && data_legal) : arr_wr_ok;
  assign start       = take && allowed;

  blg_status_core #(
    .INIT_LOCK_EN (INIT_LOCK_EN),
    .INIT_ZONE    (INIT_ZONE)
  ) u_core (
    .clk          (clk),
    .rst_n        (rst_n),
    .busy         (busy),
    .done         (done),
    .cmd_wel_set  (cmd_wel_set),
    .cmd_wel_clr  (cmd_wel_clr),
    .cmd_flag_set (cmd_flag_set),
    .cmd_flag_clr (cmd_flag_clr),
    .start_status (start && is_status),
    .pend_lock_in (req_data[7]),
    .pend_zone_in (req_data[3:2]),
    .wel          (wel),
    .flag         (flag),
    .lock_en      (lock_en),
    .zone         (zone)
  );

  assign fields      = '{lock_en: lock_en, flag: flag, zone: zone, wel: wel, wip: busy};
  assign status_byte = pack_status(fields);

  AST_NO_OK_WITHOUT_WEL: assert property (@(posedge clk) disable iff (!rst_n)
    !status_byte[1] |-> (!arr_wr_ok && !sr_wr_ok)) else $error("ok without latch"); // R2
  AST_FULL_ZONE_LOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (status_byte[3:2] == 2'b11) |-> !arr_wr_ok) else $error("full zone writable"); // R2
  AST_PIN_LOCK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (status_byte[7] && !hw_lock_n) |-> !sr_wr_ok) else $error("locked status writable"); // R3
  AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !req_ready) else $error("start without busy"); // R6
  AST_BAD_DATA_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
    (take && is_status && !data_legal) |=> req_ready) else $error("bad data taken"); // R7
endmodule

// File: tb/tb_blk_lock_guard.sv
module tb_blk_lock_guard;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 11;
  localparam int WR_CYCLES  = 8;
  localparam int DEPTH      = 1 << ADDR_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hw_lock_n = 1'b1;
  logic cmd_wel_set = 1'b0, cmd_wel_clr = 1'b0, cmd_flag_set = 1'b0, cmd_flag_clr = 1'b0;
  logic req_valid = 1'b0, req_kind = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [7:0] req_data = '0;
  logic req_ready, arr_wr_ok, sr_wr_ok;
  logic [7:0] status_byte;

  int n_run = 0, n_fail = 0;
  bit finished = 1'b0;

  // reference model state
  int m_wel, m_flag, m_lock, m_zone, m_wip, m_cnt, m_pkind, m_pdata;
  int ok_now;

  always #(CLK_PERIOD/2) clk = ~clk;

  blk_lock_guard #(.ADDR_W(ADDR_W), .WR_CYCLES(WR_CYCLES)) dut (
    .clk(clk), .rst_n(rst_n), .hw_lock_n(hw_lock_n),
    .cmd_wel_set(cmd_wel_set), .cmd_wel_clr(cmd_wel_clr),
    .cmd_flag_set(cmd_flag_set), .cmd_flag_clr(cmd_flag_clr),
    .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
    .req_addr(req_addr), .req_data(req_data),
    .arr_wr_ok(arr_wr_ok), .sr_wr_ok(sr_wr_ok), .status_byte(status_byte)
  );

  function automatic int in_zone(int a, int z);
    if (z == 0) return 0;
    if (z == 1) return (a >= DEPTH*3/4) ? 1 : 0;
    if (z == 2) return (a >= DEPTH/2) ? 1 : 0;
    return 1;
  endfunction

  function automatic int exp_status();
    return m_lock*128 + m_flag*64 + m_zone*4 + m_wel*2 + m_wip;
  endfunction
  function automatic int exp_arr_ok();
    return (m_wel != 0 && in_zone(int'(req_addr), m_zone) == 0) ? 1 : 0;
  endfunction
  function automatic int exp_sr_ok();
    return (m_wel != 0 && !(m_lock != 0 && hw_lock_n == 1'b0)) ? 1 : 0;
  endfunction

  task automatic chk(input int act, input int exp, input string tag);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural model
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_wel = 0; m_flag = 0; m_lock = 0; m_zone = 0;
      m_wip = 0; m_cnt = 0; m_pkind = 0; m_pdata = 0;
    end else if (m_wip != 0) begin
      if (m_cnt == 1) begin
        m_wip = 0; m_wel = 0;
        if (m_pkind != 0) begin
          m_lock = (m_pdata >> 7) & 1;
          m_zone = (m_pdata >> 2) & 3;
        end
      end else m_cnt--;
    end else begin
      ok_now = 0;
      if (req_valid) begin
        if (req_kind) ok_now = (exp_sr_ok() != 0 && (int'(req_data) % 4) == 0) ? 1 : 0;
        else          ok_now = exp_arr_ok();
      end
      if (ok_now != 0) begin
        m_wip = 1; m_cnt = WR_CYCLES; m_pkind = int'(req_kind); m_pdata = int'(req_data);
      end
      if (cmd_wel_clr) m_wel = 0; else if (cmd_wel_set) m_wel = 1;
      if (cmd_flag_clr) m_flag = 0; else if (cmd_flag_set) m_flag = 1;
    end
  end

  // per-clock comparison
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      #1;
      chk(int'(status_byte), exp_status(), "R1 status vs model");
      chk(int'(arr_wr_ok), exp_arr_ok(), "R2 arr_wr_ok vs model");
      chk(int'(sr_wr_ok), exp_sr_ok(), "R3 sr_wr_ok vs model");
      chk(int'(req_ready), 1 - m_wip, "R6 req_ready vs model");
    end
  end

  task automatic strobe(input bit ws, input bit wc, input bit fs, input bit fc);
    @(negedge clk);
    cmd_wel_set = ws; cmd_wel_clr = wc; cmd_flag_set = fs; cmd_flag_clr = fc;
    @(negedge clk);
    cmd_wel_set = 0; cmd_wel_clr = 0; cmd_flag_set = 0; cmd_flag_clr = 0;
    #2;
  endtask

  task automatic request(input bit kind, input int addr, input int data);
    @(negedge clk);
    req_valid = 1; req_kind = kind; req_addr = ADDR_W'(addr); req_data = 8'(data);
    @(negedge clk);
    req_valid = 0;
    #2;
  endtask

  task automatic settle();
    repeat (WR_CYCLES + 1) @(negedge clk);
    #2;
  endtask

  task automatic probe(input int addr, input int exp, input string tag);
    @(negedge clk);
    req_addr = ADDR_W'(addr);
    #2;
    chk(int'(arr_wr_ok), exp, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #2;
    chk(int'(status_byte), 8'h00, "R1 reset status");

    request(1'b0, 'h010, 0);
    chk(int'(status_byte), 8'h00, "R6 refused without latch");
    chk(int'(req_ready), 1, "R6 ready after refusal");

    strobe(1, 0, 0, 0);
    chk(int'(status_byte), 8'h02, "R4 latch set");
    probe('h7FF, 1, "R2 zone 00 top address writable");

    request(1'b0, 'h010, 0);
    chk(int'(status_byte), 8'h03, "R6 busy after accept");
    chk(int'(req_ready), 0, "R6 not ready while busy");
    strobe(0, 1, 1, 0);
    chk(int'(status_byte), 8'h03, "R4 R5 strobes ignored while busy");
    settle();
    chk(int'(status_byte), 8'h00, "R8 latch cleared at end");

    strobe(0, 0, 1, 0);
    chk(int'(status_byte), 8'h40, "R5 flag set");
    strobe(1, 0, 0, 0);
    request(1'b1, 0, 'h04);
    chk(int'(status_byte), 8'h43, "R6 status write busy");
    settle();
    chk(int'(status_byte), 8'h44, "R8 zone loaded, flag kept");

    strobe(1, 0, 0, 0);
    probe('h5FF, 1, "R2 zone 01 below boundary");
    probe('h600, 0, "R2 zone 01 at boundary");

    request(1'b1, 0, 'h05);
    chk(int'(status_byte), 8'h46, "R7 low data bits refused");

    request(1'b1, 0, 'h88);
    settle();
    chk(int'(status_byte), 8'hC8, "R8 lock-enable and zone 10 loaded");
    strobe(1, 0, 0, 0);
    probe('h3FF, 1, "R2 zone 10 below boundary");
    probe('h400, 0, "R2 zone 10 at boundary");

    @(negedge clk); hw_lock_n = 1'b0; #2;
    chk(int'(sr_wr_ok), 0, "R3 pin low locks status");
    request(1'b1, 0, 'h00);
    chk(int'(status_byte), 8'hCA, "R3 locked status write refused");
    @(negedge clk); hw_lock_n = 1'b1; #2;
    chk(int'(sr_wr_ok), 1, "R3 pin high unlocks");

    request(1'b1, 0, 'h8C);
    @(negedge clk); hw_lock_n = 1'b0;
    settle();
    chk(int'(status_byte), 8'hCC, "R9 running write completes");
    strobe(1, 0, 0, 0);
    chk(int'(sr_wr_ok), 0, "R9 later writes blocked");
    probe('h000, 0, "R2 zone 11 locks address 0");

    @(negedge clk); hw_lock_n = 1'b1;
    strobe(1, 1, 0, 0);
    chk(int'(status_byte), 8'hCC, "R4 clear wins");
    strobe(0, 0, 1, 1);
    chk(int'(status_byte), 8'h8C, "R5 clear wins");

    strobe(1, 0, 0, 0);
    request(1'b1, 0, 'h00);
    settle();
    chk(int'(status_byte), 8'h00, "R8 status cleared by write");

    strobe(0, 0, 1, 0);
    strobe(1, 0, 0, 0);
    request(1'b0, 'h7FF, 'hFF);
    settle();
    chk(int'(status_byte), 8'h40, "R10 array write leaves other bits");

    repeat (2) @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule